// File: doc/BRIEF.md
# Programmable Raster Display Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes of a raster display, together with the pixel column and line numbers of the active picture. Each line is made of four consecutive spans: active pixels, front porch, sync, and back porch. Each frame follows the same four spans, counted in whole lines. Every span length is held in its own register as its count minus one, so a stored zero means a span one unit long.

A register-write port loads the eight span lengths, a polarity word and a run command. The polarity word sets the active level of hsync, vsync and data-enable, and whether pixel data should be inverted downstream. Writing the run command with bit 0 set starts the raster at pixel 0 of line 0. Writing it with bit 0 clear parks every strobe at its inactive level and returns both counters to that origin. Two outputs are meant for an interrupt controller: a one-cycle frame-start pulse and a vertical-blank flag.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the generator is stopped, the polarity word is 4'b1111, and hsync_o, vsync_o, de_o, data_inv_o, x_o, y_o, frame_start_o and vblank_o are all 0.
- R2: Register addresses 0..3 hold the horizontal active, front porch, sync and back porch lengths minus one. A line runs through these spans in that order. hsync is active exactly during the sync span.
- R3: Register addresses 4..7 hold the vertical active, front porch, sync and back porch lengths minus one, counted in lines. Frames run through these spans in that order. vsync is active for every cycle of the sync lines.
- R4: de is active only when both the horizontal and vertical spans are active. x_o and y_o give the pixel and line index inside the active area, and are 0 elsewhere.
- R5: The polarity register at address 8 uses bit 0 for hsync, bit 1 for vsync, bit 2 for de and bit 3 for data. A set sync or de bit makes that output active high; a clear bit makes it active low. data_inv_o equals the inverse of bit 3.
- R6: Writing address 9 with bit 0 set starts the generator. On the cycle after the write edge, the outputs show pixel 0 of line 0.
- R7: Writing address 9 with bit 0 clear stops the generator on the next cycle. hsync, vsync and de go inactive, x_o, y_o, frame_start_o and vblank_o go to 0, and a later start begins again at pixel 0 of line 0.
- R8: frame_start_o is a single-cycle pulse on pixel 0 of line 0 of every frame.
- R9: vblank_o is 1 while running outside the vertical active span, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CW | Register write data |
| hsync_o | output | 1 | Horizontal sync at programmed polarity |
| vsync_o | output | 1 | Vertical sync at programmed polarity |
| de_o | output | 1 | Data enable at programmed polarity |
| data_inv_o | output | 1 | Request to invert pixel data |
| x_o | output | CW | Active pixel column |
| y_o | output | CW | Active line number |
| frame_start_o | output | 1 | One-cycle pulse at the first pixel of a frame |
| vblank_o | output | 1 | Vertical blanking flag |

## Verification
The bench goes after the off-by-one traps of the minus-one encoding. One timing set has every length at zero, so each span lasts a single cycle and the frame is four lines of four pixels. A design that treats a stored length as the count itself would then stretch every span and drift off the expected sequence. It also checks mixed polarity words, where a swapped bit would invert the wrong strobe, and a stop written in the middle of a line followed at once by a restart, where a generator that resumes instead of returning to the origin would show a nonzero column.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    PH_ACT  = 2'd0,
    PH_FP   = 2'd1,
    PH_SYNC = 2'd2,
    PH_BP   = 2'd3
  } phase_t;

  // register map: horizontal spans at 0..3, vertical at 4..7 (phase order)
  localparam logic [ADDR_W-1:0] A_V_BASE = 4'd4;
  localparam logic [ADDR_W-1:0] A_POL    = 4'd8;
  localparam logic [ADDR_W-1:0] A_CMD    = 4'd9;

  localparam int POL_HS  = 0;
  localparam int POL_VS  = 1;
  localparam int POL_DE  = 2;
  localparam int POL_DAT = 3;

  // output level for a strobe: active follows pol, idle is its inverse
  function automatic logic drive_level(input logic active, input logic pol);
    return active ? pol : ~pol;
  endfunction
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [CW-1:0]        wr_data,
  output logic [3:0][CW-1:0]   h_len,
  output logic [3:0][CW-1:0]   v_len,
  output logic [3:0]           pol,
  output logic                 run,
  output logic                 stop_req
);
  logic cmd_hit;
  assign cmd_hit  = wr_en && (wr_addr == A_CMD);
  assign stop_req = cmd_hit && !wr_data[0];

  for (genvar g = 0; g < 4; g++) begin : g_span
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        h_len[g] <= '0;
        v_len[g] <= '0;
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(g))            h_len[g] <= wr_data;
        if (wr_addr == A_V_BASE + ADDR_W'(g)) v_len[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol <= 4'b1111;
      run <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_POL) pol <= wr_data[3:0];
      if (cmd_hit)                   run <= wr_data[0];
    end
  end

  assert_cmd_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> (run == $past(wr_data[0])));
endmodule

// File: rtl/rtg_axis_counter.sv
module rtg_axis_counter
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               adv,
  input  logic [3:0][CW-1:0] len,
  output phase_t             phase,
  output logic [CW-1:0]      cnt,
  output logic               wrap
);
  // a span ends when the count reaches its stored length (count minus one);
  // >= keeps a shrunk length from overrunning
  function automatic logic span_done(input logic [CW-1:0] c, input logic [CW-1:0] l);
    return c >= l;
  endfunction

  logic last;
  assign last = span_done(cnt, len[phase]);
  assign wrap = adv && last && (phase == PH_BP);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      phase <= PH_ACT;
      cnt   <= '0;
    end else if (adv) begin
      if (last) begin
        phase <= phase_t'(phase + 2'd1);
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2 (line) and R3 (frame): spans only step forward in order
  assert_phase_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && phase != $past(phase)) |-> (phase == phase_t'($past(phase) + 2'd1)));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              data_inv_o,
  output logic [CW-1:0]     x_o,
  output logic [CW-1:0]     y_o,
  output logic              frame_start_o,
  output logic              vblank_o
);
  logic [3:0][CW-1:0] h_len, v_len;
  logic [3:0]         pol;
  logic               run, stop_req;
  phase_t             h_ph, v_ph;
  logic [CW-1:0]      h_cnt, v_cnt;
  logic               line_end, frame_end;

  rtg_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .h_len(h_len), .v_len(v_len), .pol(pol), .run(run), .stop_req(stop_req)
  );

  rtg_axis_counter #(.CW(CW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .clr(!run), .adv(1'b1), .len(h_len),
    .phase(h_ph), .cnt(h_cnt), .wrap(line_end)
  );

  rtg_axis_counter #(.CW(CW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .clr(!run), .adv(line_end), .len(v_len),
    .phase(v_ph), .cnt(v_cnt), .wrap(frame_end)
  );

  // named events
  logic h_act, v_act, hs_act, vs_act, de_act;
  assign h_act  = run && (h_ph == PH_ACT);
  assign v_act  = run && (v_ph == PH_ACT);
  assign hs_act = run && (h_ph == PH_SYNC);
  assign vs_act = run && (v_ph == PH_SYNC);
  assign de_act = h_act && v_act;

  assign hsync_o       = drive_level(hs_act, pol[POL_HS]);
  assign vsync_o       = drive_level(vs_act, pol[POL_VS]);
  assign de_o          = drive_level(de_act, pol[POL_DE]);
  assign data_inv_o    = ~pol[POL_DAT];
  assign x_o           = h_act ? h_cnt : '0;
  assign y_o           = v_act ? v_cnt : '0;
  assign frame_start_o = de_act && (h_cnt == '0) && (v_cnt == '0);
  assign vblank_o      = run && (v_ph != PH_ACT);

  assert_de_not_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    de_act |-> !vblank_o);

  assert_hsync_after_fp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_act) |-> ($past(h_ph) == PH_FP));

  assert_idle_home_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (h_cnt == '0 && v_cnt == '0 && h_ph == PH_ACT && v_ph == PH_ACT));

  assert_fs_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o);

  assert_frame_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !stop_req) |=> frame_start_o);

  assert_vsync_in_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vs_act |-> vblank_o);
endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
  localparam int CW = 12;
  localparam int NV = 4;
  // h_act, h_fp, h_sync, h_bp, v_act, v_fp, v_sync, v_bp, polarity
  localparam int VEC [NV][9] = '{
    '{3, 1, 1, 1, 2, 0, 0, 0, 5},
    '{0, 0, 0, 0, 0, 0, 0, 0, 15},
    '{5, 2, 3, 1, 3, 1, 2, 1, 6},
    '{1, 0, 2, 0, 1, 1, 0, 2, 8}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic hsync_o, vsync_o, de_o, data_inv_o, frame_start_o, vblank_o;
  logic [CW-1:0] x_o, y_o;

  raster_timing_gen #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .data_inv_o(data_inv_o),
    .x_o(x_o), .y_o(y_o), .frame_start_o(frame_start_o), .vblank_o(vblank_o)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int cfg [9];

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [3:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // t = cycles since the start command took effect
  task automatic expect_at(input int t);
    int ht, vt, hp, ln;
    bit ha, hs, va, vs;
    logic [3:0] p;
    ht = cfg[0] + cfg[1] + cfg[2] + cfg[3] + 4;
    vt = cfg[4] + cfg[5] + cfg[6] + cfg[7] + 4;
    hp = t % ht;
    ln = (t / ht) % vt;
    ha = hp < cfg[0] + 1;
    hs = (hp >= cfg[0] + cfg[1] + 2) && (hp < cfg[0] + cfg[1] + cfg[2] + 3);
    va = ln < cfg[4] + 1;
    vs = (ln >= cfg[4] + cfg[5] + 2) && (ln < cfg[4] + cfg[5] + cfg[6] + 3);
    p = cfg[8][3:0];
    cmp("R2/R5", "hsync", int'(hsync_o), int'(hs ? p[0] : !p[0]));
    cmp("R3/R5", "vsync", int'(vsync_o), int'(vs ? p[1] : !p[1]));
    cmp("R4/R5", "de", int'(de_o), int'((ha && va) ? p[2] : !p[2]));
    cmp("R4", "x", int'(x_o), ha ? hp : 0);
    cmp("R4", "y", int'(y_o), va ? ln : 0);
    cmp("R8", "frame_start", int'(frame_start_o), int'(hp == 0 && ln == 0));
    cmp("R9", "vblank", int'(vblank_o), int'(!va));
    cmp("R5", "data_inv", int'(data_inv_o), int'(!p[3]));
  endtask

  task automatic expect_idle(input string req, input logic [3:0] p);
    cmp(req, "hsync idle", int'(hsync_o), int'(!p[0]));
    cmp(req, "vsync idle", int'(vsync_o), int'(!p[1]));
    cmp(req, "de idle", int'(de_o), int'(!p[2]));
    cmp(req, "x idle", int'(x_o), 0);
    cmp(req, "y idle", int'(y_o), 0);
    cmp(req, "frame_start idle", int'(frame_start_o), 0);
    cmp(req, "vblank idle", int'(vblank_o), 0);
    cmp(req, "data_inv", int'(data_inv_o), int'(!p[3]));
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_idle("R1", 4'b1111);

    for (int v = 0; v < NV; v++) begin
      put(4'd9, 0);
      for (int k = 0; k < 9; k++) begin
        cfg[k] = VEC[v][k];
        put(4'(k), VEC[v][k]);
      end
      put(4'd9, 1);                       // R6: origin visible right after
      for (int t = 0; t < 2 * (cfg[0]+cfg[1]+cfg[2]+cfg[3]+4) * (cfg[4]+cfg[5]+cfg[6]+cfg[7]+4); t++) begin
        expect_at(t);
        @(negedge clk);
      end
    end

    // R7: stop while running, outputs go idle and stay idle
    put(4'd9, 0);
    expect_idle("R7", cfg[8][3:0]);
    repeat (3) @(negedge clk);
    expect_idle("R7", cfg[8][3:0]);

    // R6: restart begins at the origin with a frame-start pulse
    put(4'd9, 1);
    cmp("R6", "frame_start on start", int'(frame_start_o), 1);
    for (int t = 0; t < 5; t++) begin
      expect_at(t);
      @(negedge clk);
    end

    // R7: stop mid-line then restart at once, raster returns to origin
    put(4'd9, 0);
    put(4'd9, 1);
    for (int t = 0; t < 30; t++) begin
      expect_at(t);
      @(negedge clk);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R6 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end
endmodule